// File: doc/BRIEF.md
# Paged Address Mapper with Flash Routing

This block converts a 16-bit processor address into a 19-bit physical address by splitting the logical space into sixteen 4 KB pages. Each page has an 8-bit page register. The register supplies a 7-bit physical page number and a routing flag that sends the access to a flash ROM instead of RAM. The block decodes the result into one RAM chip select and one flash chip select.

Software writes the page registers through a 32-byte window in the memory map and can read them back there. Two single-bit flags in a bit-addressed I/O space control the block. One flag enables the low ROM area, and the other turns page translation on. The intended boot sequence is to fill the registers first and then set the translation flag.

With translation off, the block passes pages through one to one, and the boot page always comes from flash so that the reset vector can be fetched.

Top module: `page_mapper`

## Requirements
- R1: `phys_addr_o[11:0]` always equals `addr_i[11:0]`, in every mode.
- R2: While translation is off, `phys_addr_o[18:12]` equals `addr_i[15:12]` zero-extended. Page 0 always goes to flash. Page 1 goes to flash only while the ROM flag is 1. Every other page goes to RAM.
- R3: While translation is on, the page register indexed by `addr_i[15:12]` drives the mapping. Its bits 6:0 appear on `phys_addr_o[18:12]`, and its bit 7 set to 1 selects flash while 0 selects RAM.
- R4: A write (`wr_i`) to an address from 0xFE00 to 0xFE1F loads page register `addr_i[4:1]` from `wdata_i[15:8]`. Both byte addresses of a pair hit the same register, and the new value is used from the next cycle.
- R5: A read (`rd_i`) in that window returns the register in `rdata_o[15:8]` with `rdata_o[7:0]`=0 in the same cycle. In every other case `rdata_o` is 0.
- R6: When `io_we_i` is high, bit address 0x140 loads the ROM flag from `io_bit_i` and bit address 0x141 loads the translation flag. The new flag is used from the next cycle.
- R7: After reset, all page registers read 0 and both flags are 0.
- R8: `ram_cs_o` and `flash_cs_o` are never 1 together, and neither is 1 unless `rd_i` or `wr_i` is 1.
- R9: An access inside the page-register window asserts neither chip select.
- R10: I/O bit writes to any address other than 0x140 and 0x141 change neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor logical address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data; the high byte feeds the page registers |
| rdata_o | output | 16 | Page register read-back data |
| io_we_i | input | 1 | Single-bit I/O write strobe |
| io_addr_i | input | 12 | I/O bit address |
| io_bit_i | input | 1 | I/O bit value |
| phys_addr_o | output | 19 | Physical address: page number and offset |
| ram_cs_o | output | 1 | RAM chip select |
| flash_cs_o | output | 1 | Flash chip select |

## Verification
The physical address, both chip selects and the read-back data are combinational from the address and strobes, so they are due in the same cycle. The bench sets its inputs on the falling edge and samples 1 ns later, before the next rising edge. Page register writes and flag writes take effect at the next rising edge. Each such write is therefore held across exactly one rising edge and removed on the following falling edge, and only after that does the bench check the read-back or translation results that depend on it. The bench sweeps every page in both modes, and the expected page numbers are computed from a per-page formula.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;
  localparam int LA_W  = 16;
  localparam int OFS_W = 12;
  localparam int PPN_W = 7;
  localparam int PAGE_W = LA_W - OFS_W;
  localparam int NPAGES = 2 ** PAGE_W;
  localparam int PA_W  = PPN_W + OFS_W;
  localparam int ENT_W = PPN_W + 1;

  typedef struct packed {
    logic             flash;
    logic [PPN_W-1:0] ppn;
  } page_entry_t;
endpackage

// File: rtl/page_regfile.sv
module page_regfile
  import page_mapper_pkg::*;
#(
  parameter int N     = NPAGES,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  page_entry_t      wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output page_entry_t      rdata_o,
  input  logic [IDX_W-1:0] lidx_i,
  output page_entry_t      lentry_o
);
  page_entry_t regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))       regs[g] <= wdata_i;
    end
  end

  assign rdata_o  = regs[ridx_i];
  assign lentry_o = regs[lidx_i];
endmodule

// File: rtl/page_flags.sv
module page_flags #(
  parameter int          IO_AW     = 12,
  parameter logic [11:0] FLAG_BASE = 12'h140
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_bit_i,
  output logic             rom_en_o,
  output logic             map_en_o
);
  localparam int NFLAGS = 2;
  logic [NFLAGS-1:0] flags_q;

  // bit k of the flag register lives at FLAG_BASE + k
  for (genvar k = 0; k < NFLAGS; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[k] <= 1'b0;
      else if (io_we_i && io_addr_i == IO_AW'(FLAG_BASE + k)) flags_q[k] <= io_bit_i;
    end
  end

  assign rom_en_o = flags_q[0];
  assign map_en_o = flags_q[1];
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import page_mapper_pkg::*;
#(
  parameter int ROM_LOW_PAGES = 2
) (
  input  logic [PAGE_W-1:0] page_i,
  input  page_entry_t       entry_i,
  input  logic              map_en_i,
  input  logic              rom_en_i,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              flash_o
);
  localparam logic [PAGE_W-1:0] ROM_LIM = PAGE_W'(ROM_LOW_PAGES);

  always_comb begin
    if (map_en_i) begin
      ppn_o   = entry_i.ppn;
      flash_o = entry_i.flash;
    end else begin
      ppn_o   = PPN_W'(page_i);
      // boot page is always flash; the rest of the low area only when enabled
      flash_o = (page_i == '0) || (rom_en_i && page_i < ROM_LIM);
    end
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import page_mapper_pkg::*;
#(
  parameter logic [15:0] WIN_BASE      = 16'hFE00,
  parameter logic [11:0] FLAG_BASE     = 12'h140,
  parameter int          IO_AW         = 12,
  parameter int          ROM_LOW_PAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_bit_i,
  output logic [18:0]      phys_addr_o,
  output logic             ram_cs_o,
  output logic             flash_cs_o
);
  localparam int WIN_LSB = $clog2(2 * NPAGES);
  localparam int IDX_W   = PAGE_W;

  logic              in_win, acc, rom_en, map_en, flash;
  logic [PPN_W-1:0]  ppn;
  logic [IDX_W-1:0]  win_idx;
  page_entry_t       rd_ent, lk_ent, wr_ent;
  logic              unused_lo;

  assign in_win  = addr_i[LA_W-1:WIN_LSB] == WIN_BASE[LA_W-1:WIN_LSB];
  assign acc     = rd_i | wr_i;
  assign win_idx = addr_i[WIN_LSB-1:1];
  assign wr_ent  = wdata_i[LA_W-1 -: ENT_W];
  assign unused_lo = ^wdata_i[LA_W-ENT_W-1:0];

  page_regfile #(.N(NPAGES), .IDX_W(IDX_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_i & in_win),
    .widx_i   (win_idx),
    .wdata_i  (wr_ent),
    .ridx_i   (win_idx),
    .rdata_o  (rd_ent),
    .lidx_i   (addr_i[LA_W-1:OFS_W]),
    .lentry_o (lk_ent)
  );

  page_flags #(.IO_AW(IO_AW), .FLAG_BASE(FLAG_BASE)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .io_we_i   (io_we_i),
    .io_addr_i (io_addr_i),
    .io_bit_i  (io_bit_i),
    .rom_en_o  (rom_en),
    .map_en_o  (map_en)
  );

  addr_xlate #(.ROM_LOW_PAGES(ROM_LOW_PAGES)) i_xlate (
    .page_i   (addr_i[LA_W-1:OFS_W]),
    .entry_i  (lk_ent),
    .map_en_i (map_en),
    .rom_en_i (rom_en),
    .ppn_o    (ppn),
    .flash_o  (flash)
  );

  assign phys_addr_o = {ppn, addr_i[OFS_W-1:0]};
  assign ram_cs_o    = acc & ~in_win & ~flash;
  assign flash_cs_o  = acc & ~in_win & flash;
  assign rdata_o     = (rd_i & in_win) ? {rd_ent, {(LA_W-ENT_W){1'b0}}} : '0;
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
  parameter logic [15:0] WIN_BASE = 16'hFE00
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [15:0] rdata_o,
  input logic [18:0] phys_addr_o,
  input logic        ram_cs_o,
  input logic        flash_cs_o
);
  logic win;
  assign win = addr_i[15:5] == WIN_BASE[15:5];

  p_offset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[11:0] == addr_i[11:0]);

  p_cs_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_cs_o && flash_cs_o));

  p_cs_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> !ram_cs_o && !flash_cs_o);

  p_win_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win |-> !ram_cs_o && !flash_cs_o);

  p_rdata_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && win) |-> rdata_o == 16'h0);

  p_rdata_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7:0] == 8'h0);
endmodule

bind page_mapper page_mapper_chk #(.WIN_BASE(WIN_BASE)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .rdata_o     (rdata_o),
  .phys_addr_o (phys_addr_o),
  .ram_cs_o    (ram_cs_o),
  .flash_cs_o  (flash_cs_o)
);

// File: tb/test_page_mapper.sv
module test_page_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        io_we_i = 1'b0;
  logic [11:0] io_addr_i = '0;
  logic        io_bit_i = 1'b0;
  logic [18:0] phys_addr_o;
  logic        ram_cs_o, flash_cs_o;

  int n_cmp = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  page_mapper i_page_mapper (.*);

  function automatic logic [7:0] pval(input int i);
    return 8'((i * 53 + 17) % 256);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic rd, input logic wr, input logic [15:0] wd);
    @(negedge clk_i);
    addr_i = a; rd_i = rd; wr_i = wr; wdata_i = wd; io_we_i = 1'b0;
    #1;
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] v);
    drive(a, 1'b0, 1'b1, {v, 8'hA5});
    drive(16'h0000, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic io_wr(input logic [11:0] ba, input logic b);
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
    io_we_i = 1'b1; io_addr_i = ba; io_bit_i = b;
    @(negedge clk_i);
    io_we_i = 1'b0;
    #1;
  endtask

  task automatic chk_xl(input logic [15:0] a, input logic [6:0] ppn, input logic fl, input string req);
    drive(a, 1'b1, 1'b0, 16'h0);
    chk(32'(phys_addr_o), 32'({ppn, a[11:0]}), {req, " phys/R1"});
    chk(32'(flash_cs_o), 32'(fl), {req, " flash_cs"});
    chk(32'(ram_cs_o), 32'(!fl), {req, " ram_cs"});
  endtask

  task automatic sweep_off(input logic rom);
    for (int p = 0; p < 16; p++) begin
      logic fl;
      fl = (p == 0) || (rom && p == 1);
      chk_xl({4'(p), 12'h5A3}, 7'(p), fl, "R2");
    end
  endtask

  task automatic sweep_on;
    for (int p = 0; p < 16; p++) begin
      logic [7:0] v;
      v = pval(p);
      chk_xl({4'(p), 12'h000}, v[6:0], v[7], "R3");
      chk_xl({4'(p), 12'hFFF}, v[6:0], v[7], "R3");
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R7: reset state of registers and flags
    for (int i = 0; i < 16; i++) begin
      drive(16'hFE00 + 16'(2 * i), 1'b1, 1'b0, 16'h0);
      chk(32'(rdata_o), 32'h0, "R7 reg clear");
    end
    sweep_off(1'b0);  // R7 flags clear, R2 identity with boot page on flash

    // R8: no strobe, no select
    drive(16'h3123, 1'b0, 1'b0, 16'h0);
    chk(32'({ram_cs_o, flash_cs_o}), 32'h0, "R8 idle");
    drive(16'h3123, 1'b0, 1'b1, 16'h0);
    chk(32'({ram_cs_o, flash_cs_o}), 32'h2, "R8 write strobe selects RAM");

    // R6: ROM flag opens page 1 to flash
    io_wr(12'h140, 1'b1);
    sweep_off(1'b1);

    // R4: fill registers, alternating even/odd byte address
    for (int i = 0; i < 16; i++)
      wr_reg(16'hFE00 + 16'(2 * i + (i % 2)), pval(i));

    // R5: read back from both bytes of each pair
    for (int i = 0; i < 16; i++) begin
      drive(16'hFE00 + 16'(2 * i), 1'b1, 1'b0, 16'h0);
      chk(32'(rdata_o), 32'({pval(i), 8'h00}), "R4/R5 readback even");
      drive(16'hFE01 + 16'(2 * i), 1'b1, 1'b0, 16'h0);
      chk(32'(rdata_o), 32'({pval(i), 8'h00}), "R5 readback odd");
    end
    drive(16'h4000, 1'b1, 1'b0, 16'h0);
    chk(32'(rdata_o), 32'h0, "R5 outside window reads zero");

    // R9: window accesses select nothing
    drive(16'hFE10, 1'b1, 1'b0, 16'h0);
    chk(32'({ram_cs_o, flash_cs_o}), 32'h0, "R9 window read");
    drive(16'hFE1F, 1'b1, 1'b0, 16'h0);
    chk(32'({ram_cs_o, flash_cs_o}), 32'h0, "R9 window top");
    drive(16'hFE20, 1'b1, 1'b0, 16'h0);
    chk(32'(rdata_o), 32'h0, "R5 just above window");

    // R2: registers loaded but translation still off
    sweep_off(1'b1);

    // R6/R3: turn translation on
    io_wr(12'h141, 1'b1);
    sweep_on;

    // R10: writes to neighbouring bit addresses are ignored
    io_wr(12'h142, 1'b0);
    io_wr(12'h13F, 1'b0);
    io_wr(12'h041, 1'b0);
    chk_xl(16'h3ABC, pval(3) >> 0 & 8'h7F, pval(3) >> 7, "R10 map stays on");

    // R4: rewrite one register, effective next cycle
    wr_reg(16'hFE0A, 8'h9C);
    chk_xl(16'h5123, 7'h1C, 1'b1, "R4 rewrite page5");
    wr_reg(16'hFE0B, 8'h22);
    chk_xl(16'h5123, 7'h22, 1'b0, "R4 rewrite page5 odd");

    // R6: translation off, ROM off
    io_wr(12'h141, 1'b0);
    io_wr(12'h140, 1'b0);
    sweep_off(1'b0);

    // R7: asynchronous reset again
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    rst_ni = 1'b1;
    drive(16'hFE0A, 1'b1, 1'b0, 16'h0);
    chk(32'(rdata_o), 32'h0, "R7 reset clears");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule